// File: doc/BRIEF.md
# Prioritized Restart-Vector Interrupt Controller

This block gathers interrupt requests for an 8080-style processor and turns them into a single INT line plus a one-byte restart opcode. It has four request sources. Three come from external pins. Each external pin is caught on its rising edge and held in a pending latch. The fourth comes from the UART and is taken as a level. Software writes an enable register at one I/O address, with one bit per source. A fixed-priority picker chooses among the sources that are both requesting and enabled. Source 0 has the highest priority and the UART source the lowest.

When the processor acknowledges, the block freezes the winner and places an RST opcode on the data bus. The four sources use restart vectors 1, 3, 5 and 7, which are handler addresses 0x08, 0x18, 0x28 and 0x38. Issuing a vector clears the pending latch of that external source. A pin held high therefore produces exactly one service, even when the handler re-enables processor interrupts before it returns.

The acknowledge sequence is run by a three-state machine:

- IDLE: INT is low.
- WAIT: INT is high while an enabled request exists.
- ACK: the frozen vector is driven.

It has five transitions:

- IDLE→WAIT when any enabled request is active.
- WAIT→IDLE when none is active.
- WAIT→ACK on the acknowledge input while a request is active. This transition latches the winner and clears its pending latch.
- WAIT→IDLE on the acknowledge input when nothing is active.
- ACK→IDLE when the acknowledge input falls.

Top module: `rstvec_intc`

## Requirements
- R1: After reset, the INT output is low, the vector output is 0x00, the enable register is zero and no external request is pending.
- R2: A write strobe with the address equal to parameter EN_ADDR (default 0x4C) loads the enable register from data bits [3:0], with bit n enabling source n. A write to any other address changes nothing.
- R3: A rising edge on external request n (n = 0..2) sets its pending latch. A pin that stays high after being serviced is not serviced again.
- R4: Source 3 (the UART) is a level request. It is active only while its input is high, and dropping it before acknowledge withdraws INT.
- R5: INT is high only in WAIT, and only while at least one source is both requesting and enabled. INT is low during ACK.
- R6: Priority is fixed. Source 0 beats 1, 1 beats 2, and 2 beats 3.
- R7: From the cycle after the acknowledge input is first sampled high, and for as long as it stays high, the vector output is 0xC7 | ((2n+1) << 3). This gives 0xCF, 0xDF, 0xEF and 0xFF for n = 0..3. Outside ACK the output is 0x00.
- R8: The winner is frozen when ACK is entered. New requests during acknowledge do not change the vector byte.
- R9: Issuing a vector clears only the winner's pending latch. Two edges in the same cycle on sources 0 and 1 are serviced as 0xCF and then 0xDF.
- R10: An edge that arrives while its source is disabled stays pending. It raises INT once the source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | I/O write strobe |
| cfg_addr | input | 8 | I/O write address |
| cfg_data | input | 8 | I/O write data |
| ext_req | input | 3 | External request pins, edge captured |
| uart_req | input | 1 | UART request, level |
| cpu_inta | input | 1 | Interrupt acknowledge from the processor |
| cpu_int | output | 1 | Interrupt request to the processor |
| vec_byte | output | 8 | RST opcode during acknowledge, else 0x00 |

## Verification
Two events can fall in the same cycle: a new rising edge being captured into a pending latch, and the acknowledge that freezes the winner and clears a latch. This also covers two edges that arrive together. The bench raises sources 0 and 1 together and expects 0xCF followed by 0xDF. It also raises source 0 in the middle of an acknowledge for source 1, and expects the byte to stay 0xDF with 0xCF served on the next acknowledge. Random rounds mix enables, simultaneous edges and UART levels, and judge every vector against a priority model kept in the bench.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int IDX_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } intc_state_t;

    // RST opcode for odd restart vector 2*idx+1
    function automatic logic [7:0] rst_opcode(input logic [IDX_W-1:0] idx);
        return 8'hC7 | {2'b00, idx, 1'b1, 3'b000};
    endfunction
endpackage

// File: rtl/intc_edge_latch.sv
module intc_edge_latch #(
    parameter int N_EXT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] req_i,
    input  logic [N_EXT-1:0] clr_i,
    output logic [N_EXT-1:0] pend_o
);
    for (genvar g = 0; g < N_EXT; g++) begin : g_line
        logic prev_q;
        logic pend_q;
        logic rise;

        assign rise = req_i[g] & ~prev_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= req_i[g];
                pend_q <= (pend_q & ~clr_i[g]) | rise;
            end
        end

        assign pend_o[g] = pend_q;
    end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick
    import intc_pkg::*;
#(
    parameter int N_REQ = 4
) (
    input  logic [N_REQ-1:0] act_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (act_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |act_i;
endmodule

// File: rtl/intc_ack_fsm.sv
module intc_ack_fsm
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             inta_i,
    output logic             int_o,
    output logic             ack_o,
    output logic             take_o,
    output logic [IDX_W-1:0] win_o
);
    intc_state_t st_q, st_d;
    logic [IDX_W-1:0] win_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            win_q <= '0;
        end else begin
            st_q <= st_d;
            if (take_o) win_q <= idx_i;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (any_i) st_d = ST_WAIT;
            ST_WAIT: begin
                if (!any_i)      st_d = ST_IDLE;
                else if (inta_i) st_d = ST_ACK;
            end
            ST_ACK:  if (!inta_i) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        int_o  = 1'b0;
        ack_o  = 1'b0;
        take_o = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_WAIT: begin
                int_o  = any_i;
                take_o = any_i & inta_i;
            end
            ST_ACK:  ack_o = 1'b1;
            default: ;
        endcase
    end

    assign win_o = win_q;
endmodule

// File: rtl/rstvec_intc.sv
module rstvec_intc
    import intc_pkg::*;
#(
    parameter int         N_EXT   = 3,
    parameter logic [7:0] EN_ADDR = 8'h4C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_data,
    input  logic [N_EXT-1:0] ext_req,
    input  logic             uart_req,
    input  logic             cpu_inta,
    output logic             cpu_int,
    output logic [7:0]       vec_byte
);
    localparam int N_REQ = N_EXT + 1;

    logic [N_REQ-1:0] en_q;
    logic [N_EXT-1:0] pend;
    logic [N_EXT-1:0] clr;
    logic [N_REQ-1:0] act;
    logic             any;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] win_idx;
    logic             ack;
    logic             take;
    logic             unused_hi;

    assign unused_hi = ^cfg_data[7:N_REQ];

    always_ff @(posedge clk) begin
        if (!rst_n)                             en_q <= '0;
        else if (cfg_wr && cfg_addr == EN_ADDR) en_q <= cfg_data[N_REQ-1:0];
    end

    intc_edge_latch #(.N_EXT(N_EXT)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (ext_req),
        .clr_i (clr),
        .pend_o(pend)
    );

    assign act = {uart_req, pend} & en_q;

    intc_prio_pick #(.N_REQ(N_REQ)) u_pick (
        .act_i(act),
        .any_o(any),
        .idx_o(pick_idx)
    );

    intc_ack_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .any_i (any),
        .idx_i (pick_idx),
        .inta_i(cpu_inta),
        .int_o (cpu_int),
        .ack_o (ack),
        .take_o(take),
        .win_o (win_idx)
    );

    for (genvar g = 0; g < N_EXT; g++) begin : g_clr
        assign clr[g] = take && (pick_idx == IDX_W'(g));
    end

    assign vec_byte = ack ? rst_opcode(win_idx) : 8'h00;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int         N_REQ   = 4,
    parameter logic [7:0] EN_ADDR = 8'h4C
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [7:0]       cfg_addr,
    input logic [7:0]       cfg_data,
    input logic [N_REQ-1:0] en_q,
    input logic [N_REQ-1:0] act,
    input logic             ack,
    input logic             cpu_int,
    input logic [7:0]       vec_byte
);
    // R2
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cfg_wr && cfg_addr == EN_ADDR) |-> en_q == $past(cfg_data[N_REQ-1:0]));
    // R5
    int_quiet_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !cpu_int);
    // R6
    prio_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack) && $past(act[0])) |-> vec_byte == 8'hCF);
    // R7
    vec_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (vec_byte[7:6] == 2'b11 && vec_byte[3:0] == 4'hF));
    // R7
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> vec_byte == 8'h00);
    // R8
    vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |-> $stable(vec_byte));
endmodule

bind rstvec_intc intc_chk #(.N_REQ(N_REQ), .EN_ADDR(EN_ADDR)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .cfg_addr(cfg_addr),
    .cfg_data(cfg_data),
    .en_q    (en_q),
    .act     (act),
    .ack     (ack),
    .cpu_int (cpu_int),
    .vec_byte(vec_byte)
);

// File: tb/rstvec_intc_tb.sv
`timescale 1ns/1ps
module rstvec_intc_tb;
    localparam logic [7:0] EN = 8'h4C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_data = 8'h00;
    logic [2:0] ext_req = 3'b000;
    logic       uart_req = 1'b0;
    logic       cpu_inta = 1'b0;
    logic       cpu_int;
    logic [7:0] vec_byte;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [2:0] m_pend = 3'b000;
    logic [3:0] m_en = 4'h0;

    always #2.5 clk = ~clk;

    rstvec_intc u_dut (.*);

    function automatic logic [7:0] exp_vec(input int n);
        return 8'hC7 | 8'((2 * n + 1) << 3);
    endfunction

    function automatic int lowest(input logic [3:0] a);
        for (int i = 3; i >= 0; i--) if (a[i]) lowest = i;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_data = d;
        cyc(1);
        cfg_wr = 1'b0;
        if (a == EN) m_en = d[3:0];
    endtask

    task automatic do_ack(input logic [7:0] ev, input string tag);
        chk(cpu_int == 1'b1, {tag, " int before ack"}, cpu_int, 1);
        cpu_inta = 1'b1;
        cyc(1);
        chk(vec_byte == ev, tag, vec_byte, ev);
        chk(cpu_int == 1'b0, "R5 int low in ack", cpu_int, 0);
        cpu_inta = 1'b0;
        cyc(1);
        chk(vec_byte == 8'h00, "R7 vec idle after ack", vec_byte, 0);
        cyc(2);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk(cpu_int == 1'b0, "R1 int after reset", cpu_int, 0);
        chk(vec_byte == 8'h00, "R1 vec after reset", vec_byte, 0);
        uart_req = 1'b1;
        cyc(3);
        chk(cpu_int == 1'b0, "R1 enables cleared", cpu_int, 0);
        // R2 other address ignored
        wr(8'h4D, 8'h0F);
        cyc(3);
        chk(cpu_int == 1'b0, "R2 wrong address ignored", cpu_int, 0);
        // R4 level request
        wr(EN, 8'h0F);
        cyc(2);
        chk(cpu_int == 1'b1, "R4 uart level raises int", cpu_int, 1);
        uart_req = 1'b0;
        cyc(2);
        chk(cpu_int == 1'b0, "R4 uart drop withdraws int", cpu_int, 0);
        // R3 held pin serviced once
        ext_req[0] = 1'b1;
        cyc(3);
        do_ack(8'hCF, "R3 R7 source0 vector");
        cyc(4);
        chk(cpu_int == 1'b0, "R3 held pin not re-serviced", cpu_int, 0);
        ext_req[0] = 1'b0;
        cyc(2);
        // R9 simultaneous 0 and 1
        ext_req = 3'b011;
        cyc(3);
        do_ack(8'hCF, "R6 R9 first of pair");
        do_ack(8'hDF, "R9 second of pair");
        chk(cpu_int == 1'b0, "R9 pair drained", cpu_int, 0);
        ext_req = 3'b000;
        // R6 source 2 against UART
        ext_req[2] = 1'b1;
        uart_req = 1'b1;
        cyc(3);
        do_ack(8'hEF, "R6 source2 over uart");
        uart_req = 1'b1;
        do_ack(8'hFF, "R7 uart vector");
        uart_req = 1'b0;
        ext_req = 3'b000;
        cyc(2);
        // R10 edge while disabled
        wr(EN, 8'h0B);
        ext_req[2] = 1'b1;
        cyc(4);
        chk(cpu_int == 1'b0, "R10 disabled edge no int", cpu_int, 0);
        wr(EN, 8'h0F);
        cyc(2);
        do_ack(8'hEF, "R10 pending served after enable");
        ext_req = 3'b000;
        cyc(2);
        // R8 frozen winner
        ext_req[1] = 1'b1;
        cyc(3);
        cpu_inta = 1'b1;
        cyc(1);
        ext_req[0] = 1'b1;
        uart_req = 1'b1;
        cyc(3);
        chk(vec_byte == 8'hDF, "R8 vector frozen", vec_byte, 8'hDF);
        uart_req = 1'b0;
        cpu_inta = 1'b0;
        cyc(3);
        do_ack(8'hCF, "R8 late edge served after");
        ext_req = 3'b000;
        cyc(2);
        m_pend = 3'b000;

        // random rounds
        for (int r = 0; r < 60; r++) begin
            logic [2:0] rises;
            bit stop;
            wr(EN, 8'($urandom % 16));
            ext_req = 3'b000;
            cyc(2);
            rises = 3'($urandom % 8);
            ext_req = rises;
            m_pend = m_pend | rises;
            uart_req = 1'($urandom % 2);
            cyc(3);
            stop = 1'b0;
            for (int k = 0; k < 6 && !stop; k++) begin
                logic [3:0] a;
                int w;
                a = {uart_req, m_pend} & m_en;
                if (a == 4'h0) begin
                    chk(cpu_int == 1'b0, "R5 random no request", cpu_int, 0);
                    stop = 1'b1;
                end else begin
                    w = lowest(a);
                    do_ack(exp_vec(w), "R6 R7 random vector");
                    if (w == 3) uart_req = 1'b0;
                    else m_pend[w] = 1'b0;
                    cyc(1);
                end
            end
            ext_req = 3'b000;
            uart_req = 1'b0;
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule